// File: doc/BRIEF.md
# Complex-Integer Execution Pipe with Long-Latency Write-Back

This block tracks operations through a three-stage integer execution pipe: execute-1, execute-2 and write-back. It takes at most one operation per cycle. Each operation carries a class code and an opaque result tag. The arithmetic itself is out of scope. The pipe only decides when each operation's tag comes out as a result, and when the stage ahead of it must stop issuing.

Simple ALU operations hand their result to the bypass network at the end of execute-1. Multiply and multiply-accumulate keep going through execute-2 and report in write-back. Divide stays in write-back for a parameterised number of cycles, 33 by default. During that time both execute stages freeze and new issue is refused.

Most operations wait for their operands in the register-access stage ahead of the pipe. They are therefore accepted only when `ra_opnd_ok` is high. Multiply-accumulate is the exception: it enters execute-1 at once and waits there for `ex1_opnd_ok`.

Top module: `ipipe_longwb`

## Requirements
- R1: After reset, `byp_valid`, `late_valid` and `div_busy` are low and `issue_ready` is high.
- R2: Class codes on `issue_kind` are 0 simple, 1 multiply, 2 multiply-accumulate, 3 divide. A simple operation accepted at clock edge E gives a one-cycle `byp_valid` pulse with its tag in the cycle after E, and never gives a `late_valid` pulse.
- R3: A multiply accepted at edge E gives a one-cycle `late_valid` pulse with its tag in the third cycle after E.
- R4: A multiply-accumulate is accepted whatever the level of `ra_opnd_ok`. It stays in execute-1 while `ex1_opnd_ok` is low, and `issue_ready` stays low during that time. Its `late_valid` pulse comes two cycles after the last edge at which it waited.
- R5: A non-accumulate operation offered while `ra_opnd_ok` is low is not accepted and produces no result. Once it is accepted, its latency counts from that edge.
- R6: A divide accepted at edge E gives a one-cycle `late_valid` pulse with its tag 2 + DIV_CYC cycles after E, which is 35 by default.
- R7: While a divide sits in write-back, except in its final cycle, `div_busy` is high and `issue_ready` is low. The operations in execute-1 and execute-2 do not move, and no bypass pulse occurs.
- R8: Two divides accepted on consecutive edges produce results exactly DIV_CYC cycles apart.
- R9: A simple operation accepted on the edge after a divide still gives its bypass pulse one cycle after acceptance.
- R10: An operation held in execute-2 behind a divide enters write-back in the cycle after the divide's result. An operation held in execute-1 follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An operation is offered |
| issue_kind | input | 2 | Class code of the offered operation |
| issue_tag | input | TAG_W | Result tag of the offered operation |
| ra_opnd_ok | input | 1 | Operands of the offered operation are ready in register access |
| ex1_opnd_ok | input | 1 | Operands of the accumulate in execute-1 are ready |
| issue_ready | output | 1 | The pipe takes an operation at this edge |
| div_busy | output | 1 | A divide occupies write-back and holds the pipe |
| byp_valid | output | 1 | Execute-1 result strobe |
| byp_tag | output | TAG_W | Tag of the execute-1 result |
| late_valid | output | 1 | Write-back result strobe |
| late_tag | output | TAG_W | Tag of the write-back result |

## Verification
The assertions check, on every cycle, that a divide stall freezes both execute stages and suppresses bypass pulses. They also check that a waiting accumulate stays in execute-1 and that the divide counter steps by one per cycle. Only the bench scenarios can show the issue-to-result cycle counts of each class and the 33-cycle spacing of back-to-back divides. The same holds for the order in which operations drain after a divide, and for the refusal of operations whose register-access operands are missing.

// File: rtl/ipipe_longwb.sv
module ipipe_longwb #(
  parameter int TAG_W   = 8,
  parameter int DIV_CYC = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic [1:0]       issue_kind,
  input  logic [TAG_W-1:0] issue_tag,
  input  logic             ra_opnd_ok,
  input  logic             ex1_opnd_ok,
  output logic             issue_ready,
  output logic             div_busy,
  output logic             byp_valid,
  output logic [TAG_W-1:0] byp_tag,
  output logic             late_valid,
  output logic [TAG_W-1:0] late_tag
);
  localparam int CNT_W = $clog2(DIV_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_CYC - 1);
  localparam logic [1:0] K_SIMPLE = 2'd0;
  localparam logic [1:0] K_MUL    = 2'd1;
  localparam logic [1:0] K_MAC    = 2'd2;
  localparam logic [1:0] K_DIV    = 2'd3;

  logic             ex1_v, ex2_v, wb_v, ex1_fresh;
  logic [1:0]       ex1_k, ex2_k, wb_k;
  logic [TAG_W-1:0] ex1_tag, ex2_tag, wb_tag;
  logic [CNT_W-1:0] wb_cnt;

  logic wb_div, div_last, div_stall, mac_hold, accept;

  assign wb_div    = wb_v && (wb_k == K_DIV);
  assign div_last  = wb_div && (wb_cnt == CNT_LAST);
  assign div_stall = wb_div && !div_last;
  assign mac_hold  = ex1_v && (ex1_k == K_MAC) && !ex1_opnd_ok;
  assign accept    = issue_valid && issue_ready && (ra_opnd_ok || issue_kind == K_MAC);

  assign issue_ready = !div_stall && !mac_hold;
  assign div_busy    = div_stall;
  assign byp_valid   = ex1_v && ex1_fresh && (ex1_k == K_SIMPLE);
  assign byp_tag     = ex1_tag;
  assign late_valid  = wb_v && ((wb_k == K_MUL) || (wb_k == K_MAC) || div_last);
  assign late_tag    = wb_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex1_v <= 1'b0; ex1_fresh <= 1'b0; ex1_k <= K_SIMPLE; ex1_tag <= '0;
    end else if (!div_stall && !mac_hold) begin
      ex1_v     <= accept;
      ex1_fresh <= accept;
      ex1_k     <= issue_kind;
      ex1_tag   <= issue_tag;
    end else begin
      ex1_fresh <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex2_v <= 1'b0; ex2_k <= K_SIMPLE; ex2_tag <= '0;
    end else if (!div_stall) begin
      ex2_v   <= ex1_v && !mac_hold;
      ex2_k   <= ex1_k;
      ex2_tag <= ex1_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_v <= 1'b0; wb_k <= K_SIMPLE; wb_tag <= '0; wb_cnt <= '0;
    end else if (!div_stall) begin
      wb_v   <= ex2_v;
      wb_k   <= ex2_k;
      wb_tag <= ex2_tag;
      wb_cnt <= '0;
    end else begin
      wb_cnt <= wb_cnt + 1'b1;
    end
  end

  AST_EX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    div_stall |=> ($stable(ex1_tag) && $stable(ex2_tag) && $stable(ex1_v) && $stable(ex2_v))); // R7
  AST_NO_BYP_IN_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |=> !byp_valid); // R7
  AST_MAC_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    mac_hold |=> (ex1_v && ex1_k == K_MAC && $stable(ex1_tag))); // R4
  AST_DIV_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    div_stall |=> (wb_div && wb_cnt == CNT_W'($past(wb_cnt) + 1'b1))); // R6
endmodule

// File: tb/ipipe_longwb_tb.sv
`timescale 1ns/1ps
module ipipe_longwb_tb_top;
  localparam int TAG_W = 8;
  localparam int DIVC  = 33;

  logic clk = 1'b0, rst_n = 1'b0;
  logic issue_valid = 1'b0, ra_opnd_ok = 1'b1, ex1_opnd_ok = 1'b1;
  logic [1:0] issue_kind = 2'd0;
  logic [TAG_W-1:0] issue_tag = '0;
  logic issue_ready, div_busy, byp_valid, late_valid;
  logic [TAG_W-1:0] byp_tag, late_tag;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  ipipe_longwb #(.TAG_W(TAG_W), .DIV_CYC(DIVC)) dut_i (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_kind(issue_kind),
    .issue_tag(issue_tag), .ra_opnd_ok(ra_opnd_ok), .ex1_opnd_ok(ex1_opnd_ok),
    .issue_ready(issue_ready), .div_busy(div_busy), .byp_valid(byp_valid),
    .byp_tag(byp_tag), .late_valid(late_valid), .late_tag(late_tag));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input logic [1:0] k, input logic [TAG_W-1:0] t);
    issue_valid = v; issue_kind = k; issue_tag = t;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); drive(1'b0, 2'd0, '0); end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!byp_valid && !late_valid && !div_busy && issue_ready, "R1",
        {byp_valid, late_valid, div_busy, issue_ready}, 1);
  endtask

  task automatic t_simple;
    int byp_at = -1, late_n = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (c > 0 && byp_valid) begin
        if (byp_at < 0) byp_at = c; else byp_at = 99;
        chk(byp_tag == 8'h11, "R2 tag", byp_tag, 8'h11);
      end
      if (c > 0 && late_valid) late_n++;
      drive(c == 0, 2'd0, 8'h11);
    end
    chk(byp_at == 1, "R2 bypass cycle", byp_at, 1);
    chk(late_n == 0, "R2 no late result", late_n, 0);
  endtask

  task automatic t_mul;
    int at = -1, n = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (c > 0 && late_valid) begin n++; if (at < 0) at = c; chk(late_tag == 8'h22, "R3 tag", late_tag, 8'h22); end
      drive(c == 0, 2'd1, 8'h22);
    end
    chk(at == 3 && n == 1, "R3 mul latency", at, 3);
  endtask

  task automatic t_mac;
    int at = -1, refused = 0;
    ex1_opnd_ok = 1'b0; ra_opnd_ok = 1'b0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (c >= 1 && c <= 4 && issue_ready) refused++;
      if (c > 0 && late_valid && at < 0) begin at = c; chk(late_tag == 8'h33, "R4 tag", late_tag, 8'h33); end
      if (c == 4) ex1_opnd_ok = 1'b1;
      drive(c == 0, 2'd2, 8'h33);
    end
    ra_opnd_ok = 1'b1;
    chk(refused == 0, "R4 issue refused while waiting", refused, 0);
    chk(at == 6, "R4 mac latency", at, 6);
  endtask

  task automatic t_ra_wait;
    int at = -1;
    ra_opnd_ok = 1'b0;
    for (int c = 0; c < 14; c++) begin
      @(negedge clk);
      if (c > 0 && late_valid && at < 0) at = c;
      if (c == 5) ra_opnd_ok = 1'b1;
      drive(c <= 5, 2'd1, 8'h55);
    end
    chk(at == 8, "R5 accepted only with operands", at, 8);
  endtask

  task automatic t_div;
    int at = -1, bad_hold = 0, n = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (c >= 3 && c <= 34 && (!div_busy || issue_ready)) bad_hold++;
      if (c > 0 && late_valid) begin n++; if (at < 0) at = c; end
      if (c == 35) chk(issue_ready && !div_busy && late_tag == 8'h44, "R7 release", issue_ready, 1);
      drive(c == 0, 2'd3, 8'h44);
    end
    chk(at == 2 + DIVC && n == 1, "R6 div latency", at, 2 + DIVC);
    chk(bad_hold == 0, "R7 busy and refusal", bad_hold, 0);
  endtask

  task automatic t_div_b2b;
    int a_at = -1, b_at = -1;
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      if (c > 0 && late_valid) begin
        if (late_tag == 8'hA1) a_at = c;
        if (late_tag == 8'hB2) b_at = c;
      end
      drive(c <= 1, 2'd3, (c == 0) ? 8'hA1 : 8'hB2);
    end
    chk(a_at == 2 + DIVC, "R8 first div", a_at, 2 + DIVC);
    chk(b_at - a_at == DIVC, "R8 spacing", b_at - a_at, DIVC);
  endtask

  task automatic t_div_mix;
    int s_at = -1, d_at = -1, m_at = -1, x_at = -1;
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      if (c > 0 && byp_valid && byp_tag == 8'h5A) s_at = c;
      if (c > 0 && late_valid) begin
        if (late_tag == 8'hD0) d_at = c;
        if (late_tag == 8'h3C) m_at = c;
        if (late_tag == 8'h7E) x_at = c;
      end
      case (c)
        0: drive(1'b1, 2'd3, 8'hD0);
        1: drive(1'b1, 2'd0, 8'h5A);
        2: drive(1'b1, 2'd1, 8'h3C);
        default: drive(1'b0, 2'd0, '0);
      endcase
    end
    chk(s_at == 2, "R9 simple behind div", s_at, 2);
    chk(d_at == 2 + DIVC, "R6 div in mix", d_at, 2 + DIVC);
    chk(m_at == 4 + DIVC, "R10 drain order", m_at, 4 + DIVC);
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (c > 0 && late_valid && late_tag == 8'h7E) x_at = c;
      case (c)
        0: drive(1'b1, 2'd3, 8'hD1);
        1: drive(1'b1, 2'd1, 8'h7E);
        default: drive(1'b0, 2'd0, '0);
      endcase
    end
    idle(30);
    chk(x_at == -1, "R10 mul held behind div", x_at, -1);
    idle(10);
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_simple;  idle(2);
    t_mul;     idle(2);
    t_mac;     idle(2);
    t_ra_wait; idle(2);
    t_div;     idle(2);
    t_div_b2b; idle(2);
    t_div_mix; idle(4);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule